// File: doc/BRIEF.md
# Micro-operation expansion sequencer

This block sits between the decode and execute stages of a five-stage in-order pipeline. Decode hands it one instruction descriptor at a time: a class code, an addressing-mode bit and two register numbers. The block turns the descriptor into a short, fixed sequence of micro-operations and sends one per cycle downstream. Each micro-operation carries an opcode, two source tags, a destination tag, a memory-access flag, a writeback flag, a last flag and a step index. The sequences cover memory-operand arithmetic, memory-to-memory moves, bit operations on memory, extended multiplies, register and memory exchanges, and multi-cycle floating-point adds.

Instructions that need only one micro-operation pass straight through in the same cycle, with no register in the path. A multi-step instruction takes its descriptor at the handshake of its first micro-operation. It then keeps `in_ready` low until its final micro-operation has been accepted. When a micro-operation consumes the load result of the step before it, the sequencer leaves one empty cycle and marks the consumer for bypass. A synchronous flush drops any sequence that is in progress.

A tag is `REG_W+1` bits wide. Architectural register n is `{0,n}`. The load temporary is `{1,0..0}`. An unused tag is all zeros.

Top module: `uop_expander`

## Requirements
- R1: Class 0, class 7, and classes 1, 2 and 3 with mode 0 are single-step instructions. While idle, such an instruction appears at the outputs in the same cycle, with last=1 and step=0, and `in_ready` equals `out_ready`. Opcodes are: ALU=0, LOAD=1, STORE=2, BITST=3, MULLO=4, MULHI=5, XCHG1=6, XCHG2=7, XCHGM=8, FP=9, MOV=10, BIT=11.
  - Classes 0 and 7 and class 1 with mode 0 give ALU(a=rd, b=rs, dst=rd, wb).
  - Class 2 with mode 0 gives MOV(a=rs, b=none, dst=rd, wb).
  - Class 3 with mode 0 gives BIT(a=rd, b=rs, dst=rd, wb).
- R2: Class 1 with mode 1 gives LOAD(a=rs, b=none, dst=temp, mem, no wb), then ALU(a=rd, b=temp, dst=rd, wb).
- R3: Class 2 with mode 1 gives LOAD(a=rs, dst=temp, mem), then STORE(a=rd, b=temp, dst=none, mem, no wb).
- R4: Class 3 with mode 1 gives LOAD(a=rd, dst=temp, mem), then BITST(a=rs, b=temp, dst=none, mem, no wb).
- R5: Class 4 gives MULLO(a=rd, b=rs, dst=rd, wb), then MULHI(a=rd, b=rs, dst=(rd+1) mod 2^REG_W, wb), whatever the mode.
- R6: Class 5 with mode 0 gives XCHG1(a=rd, b=rs, dst=rd, wb), then XCHG2(a=rd, b=rs, dst=rs, wb).
- R7: Class 5 with mode 1 gives LOAD(a=rs, dst=temp, mem), then XCHGM(a=rd, b=temp, dst=rd, mem, wb).
- R8: Class 6 gives FP_STEPS micro-operations FP(a=rd, b=rs, dst=rd), and only the final one has wb=1.
- R9: The cycle after a LOAD is accepted has `out_valid` low. The next micro-operation has bypass=1. Every other micro-operation has bypass=0.
- R10: From the acceptance of a multi-step instruction's first micro-operation until its last micro-operation is accepted, `in_ready` is low and the descriptor inputs are ignored.
- R11: Micro-operation k of a sequence of length n carries step=k, and last=1 only when k=n-1.
- R12: While `flush` is high, `out_valid` and `in_ready` are low. On the cycle after a flush, the sequencer is idle.
- R13: A valid micro-operation held by `out_ready` low stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous sequence abort |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted this cycle |
| in_class | input | 3 | Instruction class code |
| in_mode | input | 1 | Addressing mode, 1 = memory operand |
| in_rd | input | REG_W | Destination / first register |
| in_rs | input | REG_W | Source / address register |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Execute stage accepts |
| out_op | output | 4 | Micro-operation opcode |
| out_src_a | output | REG_W+1 | First source tag |
| out_src_b | output | REG_W+1 | Second source tag |
| out_dst | output | REG_W+1 | Destination tag |
| out_mem | output | 1 | Accesses memory |
| out_wb | output | 1 | Writes an architectural register |
| out_last | output | 1 | Final micro-operation |
| out_step | output | $clog2(FP_STEPS) | Step index |
| out_bypass | output | 1 | Takes the previous load result by bypass |

## Verification
The bench builds the block with REG_W=3 and FP_STEPS=4. This small register file lets it sweep every class code, both modes and all 64 register pairs, which reaches the wrap of rd+1 from register 7 to register 0. A pseudo-random `out_ready` pattern stalls the sequencer at every step, including the first step and the step after the bubble. Flushes are injected during a bubble, in the middle of a multiply and in the middle of a floating-point sequence.

// File: rtl/uop_pkg.sv
package uop_pkg;

  localparam int CLS_W = 3;
  localparam int OP_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_REG  = 3'd0,
    CLS_ALU  = 3'd1,
    CLS_MOVE = 3'd2,
    CLS_BIT  = 3'd3,
    CLS_EMUL = 3'd4,
    CLS_XCHG = 3'd5,
    CLS_FADD = 3'd6,
    CLS_MISC = 3'd7
  } ins_cls_e;

  typedef enum logic [OP_W-1:0] {
    OP_ALU   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_BITST = 4'd3,
    OP_MULLO = 4'd4,
    OP_MULHI = 4'd5,
    OP_XCHG1 = 4'd6,
    OP_XCHG2 = 4'd7,
    OP_XCHGM = 4'd8,
    OP_FP    = 4'd9,
    OP_MOV   = 4'd10,
    OP_BIT   = 4'd11
  } uop_op_e;

  // Memory-operand forms whose first step is a load into the temporary.
  function automatic logic is_mem_form(ins_cls_e c, logic m);
    return m && (c == CLS_ALU || c == CLS_MOVE || c == CLS_BIT || c == CLS_XCHG);
  endfunction

endpackage

// File: rtl/uop_table.sv
module uop_table
  import uop_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int FP_STEPS = 4,
  parameter int TAG_W    = REG_W + 1,
  parameter int STEP_W   = $clog2(FP_STEPS)
) (
  input  ins_cls_e           cls,
  input  logic               mode,
  input  logic [REG_W-1:0]   rd,
  input  logic [REG_W-1:0]   rs,
  input  logic [STEP_W-1:0]  step,
  output uop_op_e            op,
  output logic [TAG_W-1:0]   src_a,
  output logic [TAG_W-1:0]   src_b,
  output logic [TAG_W-1:0]   dst,
  output logic               mem,
  output logic               wb,
  output logic               last,
  output logic               byp
);

  logic [TAG_W-1:0] t_rd, t_rs, t_rd1, t_tmp, t_none;
  logic             memf, second;
  logic [31:0]      len_m1;

  assign t_rd   = {1'b0, rd};
  assign t_rs   = {1'b0, rs};
  assign t_rd1  = {1'b0, rd + REG_W'(1)};
  assign t_tmp  = {1'b1, {REG_W{1'b0}}};
  assign t_none = '0;
  assign memf   = is_mem_form(cls, mode);
  assign second = (step != '0);

  // Sequence length minus one, per class and mode.
  always_comb begin
    if (cls == CLS_FADD)                            len_m1 = 32'(FP_STEPS - 1);
    else if (memf || cls == CLS_EMUL || cls == CLS_XCHG) len_m1 = 32'd1;
    else                                            len_m1 = 32'd0;
  end

  assign last = ({{(32-STEP_W){1'b0}}, step} == len_m1);
  assign byp  = memf && second;

  // Expansion table.
  always_comb begin
    op    = OP_ALU;
    src_a = t_rd;
    src_b = t_rs;
    dst   = t_rd;
    mem   = 1'b0;
    wb    = 1'b1;
    if (memf && !second) begin
      op    = OP_LOAD;
      src_a = (cls == CLS_BIT) ? t_rd : t_rs;
      src_b = t_none;
      dst   = t_tmp;
      mem   = 1'b1;
      wb    = 1'b0;
    end else begin
      unique case (cls)
        CLS_ALU: begin
          if (memf) src_b = t_tmp;
        end
        CLS_MOVE: begin
          if (memf) begin
            op = OP_STORE; src_b = t_tmp; dst = t_none; mem = 1'b1; wb = 1'b0;
          end else begin
            op = OP_MOV; src_a = t_rs; src_b = t_none;
          end
        end
        CLS_BIT: begin
          if (memf) begin
            op = OP_BITST; src_a = t_rs; src_b = t_tmp; dst = t_none;
            mem = 1'b1; wb = 1'b0;
          end else begin
            op = OP_BIT;
          end
        end
        CLS_EMUL: begin
          op  = second ? OP_MULHI : OP_MULLO;
          dst = second ? t_rd1 : t_rd;
        end
        CLS_XCHG: begin
          if (memf) begin
            op = OP_XCHGM; src_b = t_tmp; mem = 1'b1;
          end else begin
            op  = second ? OP_XCHG2 : OP_XCHG1;
            dst = second ? t_rs : t_rd;
          end
        end
        CLS_FADD: begin
          op = OP_FP;
          wb = last;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uop_seq_ctrl.sv
module uop_seq_ctrl
  import uop_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int STEP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  ins_cls_e           in_cls,
  input  logic               in_mode,
  input  logic [REG_W-1:0]   in_rd,
  input  logic [REG_W-1:0]   in_rs,
  input  logic               out_ready,
  output logic               out_valid,
  input  logic               tbl_last,
  input  logic               tbl_load,
  output ins_cls_e           sel_cls,
  output logic               sel_mode,
  output logic [REG_W-1:0]   sel_rd,
  output logic [REG_W-1:0]   sel_rs,
  output logic [STEP_W-1:0]  sel_step
);

  logic              busy_q, busy_d;
  logic              bub_q, bub_d;
  logic [STEP_W-1:0] step_q, step_d;
  ins_cls_e          cls_q;
  logic              mode_q;
  logic [REG_W-1:0]  rd_q, rs_q;
  logic              cap_en, fire;

  // Source select: live descriptor when idle, captured copy when busy.
  assign sel_cls  = busy_q ? cls_q  : in_cls;
  assign sel_mode = busy_q ? mode_q : in_mode;
  assign sel_rd   = busy_q ? rd_q   : in_rd;
  assign sel_rs   = busy_q ? rs_q   : in_rs;
  assign sel_step = busy_q ? step_q : '0;

  assign out_valid = !flush && (busy_q ? !bub_q : in_valid);
  assign in_ready  = !flush && !busy_q && out_ready;
  assign fire      = out_valid && out_ready;

  always_comb begin
    busy_d = busy_q;
    bub_d  = bub_q;
    step_d = step_q;
    cap_en = 1'b0;
    if (flush) begin
      busy_d = 1'b0;
      bub_d  = 1'b0;
      step_d = '0;
    end else if (busy_q && bub_q) begin
      bub_d = 1'b0;
    end else if (fire) begin
      if (tbl_last) begin
        busy_d = 1'b0;
        step_d = '0;
      end else begin
        busy_d = 1'b1;
        step_d = sel_step + STEP_W'(1);
        bub_d  = tbl_load;
        cap_en = !busy_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bub_q  <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      bub_q  <= bub_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= CLS_REG;
      mode_q <= 1'b0;
      rd_q   <= '0;
      rs_q   <= '0;
    end else if (cap_en) begin
      cls_q  <= in_cls;
      mode_q <= in_mode;
      rd_q   <= in_rd;
      rs_q   <= in_rs;
    end
  end

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !in_ready);

  assert_flush_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!busy_q && !bub_q));

  assert_load_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tbl_load && !tbl_last && !flush) |=> !out_valid);

  assert_step_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !tbl_last && !flush) |=> (step_q == $past(sel_step) + STEP_W'(1)));

  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && out_valid && !out_ready && !flush) |=> (flush || (out_valid && $stable(step_q))));

endmodule

// File: rtl/uop_expander.sv
module uop_expander
  import uop_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int FP_STEPS = 4,
  parameter int TAG_W    = REG_W + 1,
  parameter int STEP_W   = $clog2(FP_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic              in_mode,
  input  logic [REG_W-1:0]  in_rd,
  input  logic [REG_W-1:0]  in_rs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_op,
  output logic [TAG_W-1:0]  out_src_a,
  output logic [TAG_W-1:0]  out_src_b,
  output logic [TAG_W-1:0]  out_dst,
  output logic              out_mem,
  output logic              out_wb,
  output logic              out_last,
  output logic [STEP_W-1:0] out_step,
  output logic              out_bypass
);

  ins_cls_e          sel_cls;
  logic              sel_mode;
  logic [REG_W-1:0]  sel_rd, sel_rs;
  logic [STEP_W-1:0] sel_step;
  uop_op_e           tbl_op;
  logic              tbl_last;

  uop_seq_ctrl #(.REG_W(REG_W), .STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cls    (ins_cls_e'(in_class)),
    .in_mode   (in_mode),
    .in_rd     (in_rd),
    .in_rs     (in_rs),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .tbl_last  (tbl_last),
    .tbl_load  (tbl_op == OP_LOAD),
    .sel_cls   (sel_cls),
    .sel_mode  (sel_mode),
    .sel_rd    (sel_rd),
    .sel_rs    (sel_rs),
    .sel_step  (sel_step)
  );

  uop_table #(.REG_W(REG_W), .FP_STEPS(FP_STEPS), .TAG_W(TAG_W), .STEP_W(STEP_W)) u_table (
    .cls   (sel_cls),
    .mode  (sel_mode),
    .rd    (sel_rd),
    .rs    (sel_rs),
    .step  (sel_step),
    .op    (tbl_op),
    .src_a (out_src_a),
    .src_b (out_src_b),
    .dst   (out_dst),
    .mem   (out_mem),
    .wb    (out_wb),
    .last  (tbl_last),
    .byp   (out_bypass)
  );

  assign out_op   = tbl_op;
  assign out_last = tbl_last;
  assign out_step = sel_step;

  assert_mulhi_next_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !flush && out_op == 4'(OP_MULLO)) |=>
      (flush || (out_valid && out_op == 4'(OP_MULHI) &&
                 out_dst == {1'b0, $past(out_dst[REG_W-1:0]) + REG_W'(1)})));

  assert_fp_single_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 4'(OP_FP) && !out_last) |-> !out_wb);

  assert_flush_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !in_ready));

endmodule

// File: tb/uop_expander_tb.sv
`timescale 1ns/1ps
module uop_expander_tb;

  localparam int REG_W    = 3;
  localparam int FP_STEPS = 4;
  localparam int TAG_W    = REG_W + 1;
  localparam int STEP_W   = 2;
  localparam int TMP      = 8;

  logic clk, rst_n, flush, in_valid, in_ready, in_mode, out_valid, out_ready;
  logic [2:0] in_class;
  logic [REG_W-1:0] in_rd, in_rs;
  logic [3:0] out_op;
  logic [TAG_W-1:0] out_src_a, out_src_b, out_dst;
  logic out_mem, out_wb, out_last, out_bypass;
  logic [STEP_W-1:0] out_step;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  uop_expander #(.REG_W(REG_W), .FP_STEPS(FP_STEPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_mode(in_mode), .in_rd(in_rd), .in_rs(in_rs),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_mem(out_mem), .out_wb(out_wb), .out_last(out_last),
    .out_step(out_step), .out_bypass(out_bypass)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit memf_of(int cls, int mode);
    return (mode == 1) && (cls == 1 || cls == 2 || cls == 3 || cls == 5);
  endfunction

  function automatic int len_of(int cls, int mode);
    if (cls == 6) return FP_STEPS;
    if (memf_of(cls, mode) || cls == 4 || cls == 5) return 2;
    return 1;
  endfunction

  function automatic string req_of(int cls, int mode);
    case (cls)
      1: return mode ? "R2" : "R1";
      2: return mode ? "R3" : "R1";
      3: return mode ? "R4" : "R1";
      4: return "R5";
      5: return mode ? "R7" : "R6";
      6: return "R8";
      default: return "R1";
    endcase
  endfunction

  // {op, a, b, dst, mem, wb, byp} from the requirement text.
  function automatic logic [18:0] exp_body(int cls, int mode, int rd, int rs, int st);
    int op, a, b, d, m, w, y;
    op = 0; a = rd; b = rs; d = rd; m = 0; w = 1; y = 0;
    if (memf_of(cls, mode) && st == 0) begin
      op = 1; a = (cls == 3) ? rd : rs; b = 0; d = TMP; m = 1; w = 0;
    end else begin
      y = memf_of(cls, mode) ? 1 : 0;
      case (cls)
        1: if (mode == 1) b = TMP;
        2: if (mode == 1) begin op = 2; b = TMP; d = 0; m = 1; w = 0; end
           else begin op = 10; a = rs; b = 0; end
        3: if (mode == 1) begin op = 3; a = rs; b = TMP; d = 0; m = 1; w = 0; end
           else op = 11;
        4: if (st == 0) op = 4; else begin op = 5; d = (rd + 1) % 8; end
        5: if (mode == 1) begin op = 8; b = TMP; m = 1; end
           else if (st == 0) op = 6; else begin op = 7; d = rs; end
        6: begin op = 9; w = (st == FP_STEPS - 1) ? 1 : 0; end
        default: ;
      endcase
    end
    return {op[3:0], a[3:0], b[3:0], d[3:0], m[0], w[0], y[0]};
  endfunction

  function automatic logic [18:0] act_body();
    return {out_op, out_src_a, out_src_b, out_dst, out_mem, out_wb, out_bypass};
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_instr(input int cls, input int mode, input int rd, input int rs);
    int st = 0;
    int len = len_of(cls, mode);
    bit bub = 0;
    bit hold = 0;
    logic [21:0] prev = '0;
    logic [21:0] cur;
    string rq = req_of(cls, mode);
    while (st < len) begin
      @(negedge clk);
      step_lfsr();
      out_ready = (lfsr[1:0] != 2'b00);
      in_valid  = 1'b1;
      if (st == 0 && !bub) begin
        in_class = 3'(cls); in_mode = 1'(mode); in_rd = 3'(rd); in_rs = 3'(rs);
      end else begin
        // a different descriptor offered mid-sequence must be ignored (R10)
        in_class = 3'(cls ^ 3); in_mode = 1'(~mode); in_rd = 3'(~rd); in_rs = 3'(rs + 3);
      end
      #1;
      if (bub) begin
        chk(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b0, "R10", {31'd0, in_ready}, 32'd0);
        bub = 0;
      end else begin
        cur = {act_body(), out_last, out_step};
        chk(out_valid == 1'b1, rq, {31'd0, out_valid}, 32'd1);
        chk(act_body() == exp_body(cls, mode, rd, rs, st), rq,
            {13'd0, act_body()}, {13'd0, exp_body(cls, mode, rd, rs, st)});
        chk({out_last, out_step} == {(st == len - 1) ? 1'b1 : 1'b0, 2'(st)}, "R11",
            {29'd0, out_last, out_step}, {29'd0, (st == len - 1) ? 1'b1 : 1'b0, 2'(st)});
        chk(in_ready == ((st == 0) ? out_ready : 1'b0), (st == 0) ? "R1" : "R10",
            {31'd0, in_ready}, {31'd0, (st == 0) ? out_ready : 1'b0});
        if (hold) chk(cur == prev, "R13", {10'd0, cur}, {10'd0, prev});
        if (out_ready) begin
          hold = 0;
          st++;
          if (st == 1 && memf_of(cls, mode) && len > 1) bub = 1;
        end else begin
          hold = 1;
          prev = cur;
        end
      end
      @(posedge clk);
    end
  endtask

  task automatic flush_case(input int cls, input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      out_ready = 1'b1;
      in_valid  = (c == 0);
      in_class  = 3'(cls); in_mode = 1'(mode); in_rd = 3'd5; in_rs = 3'd2;
      @(posedge clk);
    end
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R12", {30'd0, out_valid, in_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R12", {30'd0, out_valid, in_ready}, 32'd1);
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_class = '0; in_mode = 1'b0; in_rd = '0; in_rs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(posedge clk);

    for (int cls = 0; cls < 8; cls++)
      for (int mode = 0; mode < 2; mode++)
        for (int rd = 0; rd < 8; rd++)
          for (int rs = 0; rs < 8; rs++)
            run_instr(cls, mode, rd, rs);

    flush_case(1, 1, 1);   // during the load bubble
    flush_case(4, 0, 1);   // between MULLO and MULHI
    flush_case(6, 0, 2);   // mid floating-point sequence
    run_instr(6, 0, 7, 1); // clean restart after flush
    run_instr(4, 1, 7, 3);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule